// File: doc/BRIEF.md
# Four-Channel Word DMA Engine

This block moves 32-bit words without processor help. It has four channels, and each one keeps its own transfer context. Software loads a channel in one cycle through a configuration strobe. The load gives the channel a source address, a destination address, a word count and a transfer kind. The kind chooses how the words travel: from a receive FIFO port into memory, from memory out to a transmit FIFO port, or from one memory region to another.

Once started, a channel takes part in a round-robin contest with the other channels that can move a word now. Each grant moves exactly one word and takes three cycles: arbitrate, read, write. Memory is a single synchronous port with one cycle of read latency. FIFO ports use show-ahead receive queues and transmit queues that report full. A channel whose source queue is empty or whose destination queue is full is simply not eligible, so no word is ever lost.

Software can poll a per-channel busy flag, or it can go on with other work and later look at a sticky done flag.

Top module: `dma4_engine`

## Requirements
- R1: After a synchronous reset, every busy and done flag is 0, and the engine asserts no memory request, no receive pop and no transmit push.
- R2: A start for an idle channel with a legal kind raises that channel's busy flag from the next cycle and clears its done flag in that same cycle.
- R3: Kind 0 (port to memory) pops words from receive port `src[1:0]` and writes them to memory at `dst`, `dst+1`, and so on. The port stays the same for the whole transfer.
- R4: Kind 1 (memory to port) reads memory from `src` upward and pushes each word, in order, to transmit port `dst[1:0]`. Higher address bits do not affect which port is chosen.
- R5: Kind 2 (memory to memory) copies words from `src+i` to `dst+i`, with both addresses advancing by one per word. The word just past the block is not touched.
- R6: A programmed count of 0 moves 2^CW words. Any other value moves exactly that many words.
- R7: While its source receive port is empty, a port-to-memory channel stays busy, pops nothing and writes nothing. It continues once data arrives.
- R8: While its destination transmit port is full, a memory-to-port channel stays busy and pushes nothing. It continues once space appears.
- R9: Channels that are ready at the same time are served one word per grant in rotating order. When all four channels are ready, consecutive words go to channels c, c+1, c+2, and so on, modulo 4.
- R10: Busy falls and done rises together when the last word is written. Done then stays set until that channel is started again.
- R11: A start for a channel that is already busy is ignored. A start with kind 3 is ignored and leaves both flags of that channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Load and start the selected channel |
| cfg_chan | input | 2 | Channel to load |
| cfg_kind | input | 2 | 0 port to memory, 1 memory to port, 2 memory to memory, 3 illegal |
| cfg_src | input | AW | Source address; low 2 bits give the port for kind 0 |
| cfg_dst | input | AW | Destination address; low 2 bits give the port for kind 1 |
| cfg_count | input | CW | Word count, 0 meaning 2^CW |
| ch_busy | output | NCH | Channel is transferring |
| ch_done | output | NCH | Sticky completion flag |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after the request |
| rx_data | input | NPORT*DW | Head word of each receive queue |
| rx_empty | input | NPORT | Receive queue empty |
| rx_pop | output | NPORT | Take the head word |
| tx_data | output | DW | Word to push |
| tx_full | input | NPORT | Transmit queue full |
| tx_push | output | NPORT | Push tx_data |

## Verification
Memory is filled with a pattern computed from the address. Each kind is then run with its own port choice and count, which separates correct address stepping, port selection and block length from off-by-one and wrong-port faults. The receive queue is kept empty and a transmit queue is held full for long stretches, which separates a real stall from a transfer that pops or pushes anyway. All four channels are released together against the pushes to four ports, so the observed order shows true rotation rather than a fixed priority. Restarting, issuing an illegal kind and starting a busy channel show whether done is sticky and whether an ignored start leaves a running transfer alone.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic [1:0] {
    XK_P2M = 2'd0,
    XK_M2P = 2'd1,
    XK_M2M = 2'd2,
    XK_BAD = 2'd3
  } xkind_t;

  typedef enum logic [1:0] {
    ST_ARB = 2'd0,
    ST_RD  = 2'd1,
    ST_WR  = 2'd2
  } seq_t;
endpackage

// File: rtl/dma_chan_ctx.sv
module dma_chan_ctx #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    cfg_kind,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic          step,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [1:0]    kind,
  output logic          busy,
  output logic          done
);
  import dma4_pkg::*;

  logic [CW:0] rem;
  logic        accept;

  assign accept = start && !busy && (cfg_kind != XK_BAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      rem      <= '0;
      src_addr <= '0;
      dst_addr <= '0;
      kind     <= XK_P2M;
    end else if (accept) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      src_addr <= cfg_src;
      dst_addr <= cfg_dst;
      kind     <= cfg_kind;
      rem      <= (cfg_count == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, cfg_count};
    end else if (step) begin
      if (kind != XK_P2M) src_addr <= src_addr + 1'b1;
      if (kind != XK_M2P) dst_addr <= dst_addr + 1'b1;
      rem <= rem - 1'b1;
      if (rem == {{CW{1'b0}}, 1'b1}) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assert_step_busy_R10: assert property (@(posedge clk) disable iff (rst)
    step |-> busy);
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy && !done);
  assert_count_live_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> rem != '0);
  assert_ignore_R11: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !step) |=> $stable(src_addr) && $stable(dst_addr) && $stable(rem));
endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx
);
  logic [IW-1:0] ptr;
  logic          found;

  always_comb begin
    grant = '0;
    gidx  = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[IW'((int'(ptr) + k) % N)]) begin
        found = 1'b1;
        grant[IW'((int'(ptr) + k) % N)] = 1'b1;
        gidx  = IW'((int'(ptr) + k) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (take) ptr <= (int'(gidx) == N - 1) ? '0 : gidx + 1'b1;
  end

  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  assert_grant_req_R9: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);
  assert_grant_live_R9: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> (grant != '0));
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int NCH   = 4,
  parameter int NPORT = 4,
  localparam int CHW  = $clog2(NCH),
  localparam int PW   = $clog2(NPORT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_start,
  input  logic [CHW-1:0]      cfg_chan,
  input  logic [1:0]          cfg_kind,
  input  logic [AW-1:0]       cfg_src,
  input  logic [AW-1:0]       cfg_dst,
  input  logic [CW-1:0]       cfg_count,
  output logic [NCH-1:0]      ch_busy,
  output logic [NCH-1:0]      ch_done,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  input  logic [NPORT*DW-1:0] rx_data,
  input  logic [NPORT-1:0]    rx_empty,
  output logic [NPORT-1:0]    rx_pop,
  output logic [DW-1:0]       tx_data,
  input  logic [NPORT-1:0]    tx_full,
  output logic [NPORT-1:0]    tx_push
);
  import dma4_pkg::*;

  logic [AW-1:0]  src_a [NCH];
  logic [AW-1:0]  dst_a [NCH];
  logic [1:0]     kind_a [NCH];
  logic [NCH-1:0] step_v;
  logic [NCH-1:0] ready;
  logic [NCH-1:0] grant;
  logic [CHW-1:0] gidx;
  logic           take;

  seq_t           st;
  logic [CHW-1:0] cur;
  logic [DW-1:0]  hold;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_chan_ctx #(.AW(AW), .CW(CW)) u_ctx (
      .clk       (clk),
      .rst       (rst),
      .start     (cfg_start && (cfg_chan == CHW'(i))),
      .cfg_kind  (cfg_kind),
      .cfg_src   (cfg_src),
      .cfg_dst   (cfg_dst),
      .cfg_count (cfg_count),
      .step      (step_v[i]),
      .src_addr  (src_a[i]),
      .dst_addr  (dst_a[i]),
      .kind      (kind_a[i]),
      .busy      (ch_busy[i]),
      .done      (ch_done[i])
    );
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ready[i] = ch_busy[i]
               && !((kind_a[i] == XK_P2M) && rx_empty[src_a[i][PW-1:0]])
               && !((kind_a[i] == XK_M2P) && tx_full[dst_a[i][PW-1:0]]);
    end
  end

  assign take = (st == ST_ARB) && (ready != '0);

  dma_rr_arb #(.N(NCH)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .req   (ready),
    .take  (take),
    .grant (grant),
    .gidx  (gidx)
  );

  logic [AW-1:0] src_c, dst_c;
  logic [1:0]    kind_c;
  logic [PW-1:0] sp_c, dp_c;
  logic [DW-1:0] wr_val;

  assign src_c  = src_a[cur];
  assign dst_c  = dst_a[cur];
  assign kind_c = kind_a[cur];
  assign sp_c   = src_c[PW-1:0];
  assign dp_c   = dst_c[PW-1:0];
  assign wr_val = (kind_c == XK_P2M) ? hold : mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_ARB;
      cur  <= '0;
      hold <= '0;
    end else begin
      case (st)
        ST_ARB: if (take) begin
          cur <= gidx;
          st  <= ST_RD;
        end
        ST_RD: begin
          if (kind_c == XK_P2M) hold <= rx_data[sp_c*DW +: DW];
          st <= ST_WR;
        end
        default: st <= ST_ARB;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    rx_pop    = '0;
    tx_push   = '0;
    tx_data   = '0;
    step_v    = '0;
    case (st)
      ST_RD: begin
        if (kind_c == XK_P2M) rx_pop[sp_c] = 1'b1;
        else begin
          mem_req  = 1'b1;
          mem_addr = src_c;
        end
      end
      ST_WR: begin
        step_v[cur] = 1'b1;
        if (kind_c == XK_M2P) begin
          tx_push[dp_c] = 1'b1;
          tx_data       = wr_val;
        end else begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = dst_c;
          mem_wdata = wr_val;
        end
      end
      default: ;
    endcase
  end

  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_pop & rx_empty) == '0);
  assert_push_room_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_push & tx_full) == '0);
  assert_one_port_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rx_pop) && $onehot0(tx_push));
  assert_write_after_read_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> $past(st) == ST_RD);
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && (tx_push != '0 || rx_pop != '0)) || (mem_we == 1'b0 && tx_push == '0) || (rx_pop == '0));
endmodule

// File: tb/dma4_engine_test.sv
module dma4_engine_test;
  localparam int AW = 8, DW = 32, CW = 4, NCH = 4, NPORT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic                cfg_start = 1'b0;
  logic [1:0]          cfg_chan = '0;
  logic [1:0]          cfg_kind = '0;
  logic [AW-1:0]       cfg_src = '0, cfg_dst = '0;
  logic [CW-1:0]       cfg_count = '0;
  logic [NCH-1:0]      ch_busy, ch_done;
  logic                mem_req, mem_we;
  logic [AW-1:0]       mem_addr;
  logic [DW-1:0]       mem_wdata, mem_rdata;
  logic [NPORT*DW-1:0] rx_data;
  logic [NPORT-1:0]    rx_empty, rx_pop, tx_push;
  logic [NPORT-1:0]    tx_blk = '0;
  logic [DW-1:0]       tx_data;

  dma4_engine #(.AW(AW), .DW(DW), .CW(CW), .NCH(NCH), .NPORT(NPORT)) uut (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_chan(cfg_chan),
    .cfg_kind(cfg_kind), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .ch_busy(ch_busy), .ch_done(ch_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_data(rx_data),
    .rx_empty(rx_empty), .rx_pop(rx_pop), .tx_data(tx_data),
    .tx_full(tx_blk), .tx_push(tx_push)
  );

  logic [DW-1:0] mem [256];
  logic [DW-1:0] rx_q [NPORT][64];
  int            rx_wp [NPORT];
  int            rx_rp [NPORT];
  logic [DW-1:0] tx_log [NPORT][64];
  int            tx_cnt [NPORT];
  int            seq [256];
  int            push_n = 0;
  int            checks = 0, errors = 0;

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hA5000000 + a * 257;
  endfunction

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      rx_data[p*DW +: DW] = rx_q[p][rx_rp[p] % 64];
      rx_empty[p]         = (rx_wp[p] == rx_rp[p]);
    end
  end

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    for (int p = 0; p < NPORT; p++) begin
      if (rx_pop[p]) rx_rp[p] <= rx_rp[p] + 1;
      if (tx_push[p]) begin
        tx_log[p][tx_cnt[p] % 64] <= tx_data;
        tx_cnt[p]   <= tx_cnt[p] + 1;
        seq[push_n % 256] <= p;
        push_n      <= push_n + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_ch(input int ch, input int kind, input int src, input int dst, input int cnt);
    @(negedge clk);
    cfg_start = 1'b1; cfg_chan = 2'(ch); cfg_kind = 2'(kind);
    cfg_src = AW'(src); cfg_dst = AW'(dst); cfg_count = CW'(cnt);
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic wait_done(input int ch);
    int n = 0;
    while (!ch_done[ch] && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) chk("R10 done timeout", 32'(ch_done[ch]), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = pat(a);
    for (int p = 0; p < NPORT; p++) begin
      rx_wp[p] = 0; rx_rp[p] = 0; tx_cnt[p] = 0;
      for (int k = 0; k < 64; k++) rx_q[p][k] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(ch_busy), 32'd0);
    chk("R1 done", 32'(ch_done), 32'd0);
    chk("R1 bus idle", {mem_req, rx_pop, tx_push}, 32'd0);

    // R5 memory to memory, R2 busy rises
    start_ch(0, 2, 10, 100, 5);
    chk("R2 busy after start", 32'(ch_busy[0]), 32'd1);
    wait_done(0);
    for (int i = 0; i < 5; i++) chk("R5 copy", mem[100+i], pat(10+i));
    chk("R5 past end untouched", mem[105], pat(105));
    chk("R10 busy clear at end", 32'(ch_busy[0]), 32'd0);

    // R7 stall on empty rx, then R3 port to memory
    start_ch(1, 0, 2, 150, 6);
    repeat (40) @(negedge clk);
    chk("R7 still busy", 32'(ch_busy[1]), 32'd1);
    chk("R7 no pop", 32'(rx_rp[2]), 32'd0);
    chk("R7 no write", mem[150], pat(150));
    for (int k = 0; k < 6; k++) begin
      rx_q[2][k] = 32'hC0DE0000 + k;
      rx_wp[2] = k + 1;
      repeat (5) @(negedge clk);
    end
    wait_done(1);
    for (int k = 0; k < 6; k++) chk("R3 word", mem[150+k], 32'hC0DE0000 + k);
    chk("R3 port drained", 32'(rx_rp[2]), 32'd6);
    chk("R3 next untouched", mem[156], pat(156));

    // R8 stall on full tx, R4 memory to port (addr 0x21 selects port 1)
    tx_blk = 4'b0010;
    start_ch(2, 1, 40, 8'h21, 7);
    repeat (40) @(negedge clk);
    chk("R8 still busy", 32'(ch_busy[2]), 32'd1);
    chk("R8 no push", 32'(tx_cnt[1]), 32'd0);
    tx_blk = '0;
    wait_done(2);
    chk("R4 count", 32'(tx_cnt[1]), 32'd7);
    for (int k = 0; k < 7; k++) chk("R4 word", tx_log[1][k], pat(40+k));
    chk("R4 other ports", 32'(tx_cnt[0] + tx_cnt[2] + tx_cnt[3]), 32'd0);

    // R6 count 0 means 2^CW words
    start_ch(3, 2, 60, 200, 0);
    wait_done(3);
    for (int i = 0; i < 16; i++) chk("R6 copy", mem[200+i], pat(60+i));
    chk("R6 past end untouched", mem[216], pat(216));

    // R10 done sticky, R2 restart clears done
    repeat (30) @(negedge clk);
    chk("R10 done sticky ch3", 32'(ch_done[3]), 32'd1);
    chk("R10 done sticky ch0", 32'(ch_done[0]), 32'd1);
    start_ch(0, 2, 0, 250, 1);
    chk("R2 done cleared", 32'(ch_done[0]), 32'd0);
    wait_done(0);
    chk("R2 single word", mem[250], pat(0));

    // R11 illegal kind and start while busy
    start_ch(1, 3, 5, 5, 3);
    repeat (3) @(negedge clk);
    chk("R11 kind3 busy", 32'(ch_busy[1]), 32'd0);
    chk("R11 kind3 done kept", 32'(ch_done[1]), 32'd1);
    tx_blk = 4'b1111;
    start_ch(2, 1, 20, 0, 2);
    start_ch(2, 1, 30, 3, 5);
    tx_blk = '0;
    wait_done(2);
    chk("R11 original count", 32'(tx_cnt[0]), 32'd2);
    chk("R11 word0", tx_log[0][0], pat(20));
    chk("R11 word1", tx_log[0][1], pat(21));
    chk("R11 second ignored", 32'(tx_cnt[3]), 32'd0);

    // R9 round robin across four ready channels
    tx_blk = 4'b1111;
    for (int c = 0; c < 4; c++) tx_cnt[c] = 0;
    for (int c = 0; c < 4; c++) start_ch(c, 1, 16*c, c, 3);
    begin
      int base;
      base = push_n;
      tx_blk = '0;
      for (int c = 0; c < 4; c++) wait_done(c);
      chk("R9 total", 32'(push_n - base), 32'd12);
      for (int k = base + 1; k < base + 12; k++)
        chk("R9 rotation", 32'(seq[k]), 32'((seq[k-1] + 1) % 4));
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 3; k++) chk("R9 data", tx_log[c][k], pat(16*c + k));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule